// File: doc/BRIEF.md
# Power-Control Test Bit Generator

This block generates the transmit-power-control bit stream used while testing a terminal's closed-loop power control. Each slot strobe produces one new output bit, and a mode input selects the kind of sequence. Three modes have no user pattern: a stream that flips on every slot, a constant 1 and a constant 0. Three modes play a user pattern once and then go on with a tail, which is either the flipping stream, a constant 1 or a constant 0. One mode repeats the user pattern without end.

The block keeps the last bit it transmitted in a register. A start pulse does not change that register. A flipping stream therefore always begins with the complement of the bit that went out just before it. That bit may come from an earlier mode or from the end of the user pattern. A done flag shows that a one-shot pattern has finished. It stays high until the next start.

Top module: `tpc_pattern_gen`

## Requirements
- R1: After reset, `bit_o` is 0 and `done_o` is 0.
- R2: `bit_o` changes only on a clock edge where `slot_i` is high. Between strobes it holds its value.
- R3: Modes 0 (flip) and 3 (pattern once, then flip), once past the pattern: each strobe outputs the complement of the previous `bit_o`. This includes the first strobe after a mode change or after the pattern ends.
- R4: Mode 1 outputs 1 on every strobe. Mode 2 outputs 0 on every strobe. Mode code 7 behaves like mode 2.
- R5: Pattern modes send `pat_i` starting at bit 0, for `len_i` bits. A `len_i` of 0 counts as 1, and a `len_i` above `PAT_W` counts as `PAT_W`.
- R6: Modes 3, 4 and 5 send the pattern once. They then continue with the flipping stream (mode 3), constant 1 (mode 4) or constant 0 (mode 5).
- R7: Mode 6 repeats the pattern back to back with no gap, and `done_o` does not change while mode 6 is selected.
- R8: `done_o` rises on the strobe that sends the last pattern bit of a one-shot mode. It then stays high until a start pulse. A start pulse with no strobe clears it in the next cycle.
- R9: A start pulse resets the pattern position to bit 0 and leaves `bit_o` unchanged. If a strobe arrives in the same cycle as the start pulse, that strobe sends pattern bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Sequence mode, codes 0 to 7 |
| start_i | input | 1 | Restart pulse |
| slot_i | input | 1 | Slot strobe, one bit per pulse |
| pat_i | input | PAT_W | User pattern, bit 0 sent first |
| len_i | input | $clog2(PAT_W+1) | Pattern length in bits |
| bit_o | output | 1 | Current transmitted bit |
| done_o | output | 1 | One-shot pattern finished |

## Verification
The checker assumes that `mode_i`, `pat_i` and `len_i` are stable over each strobe and change only at the half-period where the bench drives. It also assumes that strobes and start pulses last exactly one cycle. The bench changes inputs only on the falling edge and holds `pat_i` and `len_i` constant for a whole run. It raises `start_i` together with `slot_i` only in the one scenario that tests that case, because the done-clear property requires a start pulse without a strobe.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   typedef enum logic [2:0] {
      M_FLIP       = 3'd0,
      M_ONES       = 3'd1,
      M_ZEROS      = 3'd2,
      M_ONCE_FLIP  = 3'd3,
      M_ONCE_ONES  = 3'd4,
      M_ONCE_ZEROS = 3'd5,
      M_LOOP       = 3'd6,
      M_SPARE      = 3'd7
   } tpc_mode_e;

   function automatic logic is_once(input tpc_mode_e m);
      return (m == M_ONCE_FLIP) || (m == M_ONCE_ONES) || (m == M_ONCE_ZEROS);
   endfunction

endpackage

// File: rtl/tpc_seq_ctrl.sv
module tpc_seq_ctrl
   import tpc_pkg::*;
#(
   parameter int PAT_W = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tpc_mode_e        mode,
   input  logic             start,
   input  logic             slot,
   input  logic [IDX_W-1:0] last_idx,
   output logic [IDX_W-1:0] cur_idx,
   output logic             use_pat,
   output logic             done
);

   logic [IDX_W-1:0] idx_q, idx_d;
   logic             live_q, live_d;
   logic             done_q, done_d;
   logic             cur_live, cur_done, at_end;

   // a start pulse takes effect in the same cycle as a coincident strobe
   assign cur_idx  = start ? '0 : idx_q;
   assign cur_live = start | live_q;
   assign cur_done = start ? 1'b0 : done_q;
   assign at_end   = (cur_idx >= last_idx);
   assign use_pat  = (mode == M_LOOP) || (is_once(mode) && cur_live);

   always_comb begin
      idx_d  = cur_idx;
      live_d = cur_live;
      done_d = cur_done;
      if (slot && use_pat) begin
         if (at_end) begin
            idx_d = '0;
            if (is_once(mode)) begin
               live_d = 1'b0;
               done_d = 1'b1;
            end
         end else begin
            idx_d = cur_idx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         live_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         idx_q  <= idx_d;
         live_q <= live_d;
         done_q <= done_d;
      end
   end

   assign done = done_q;

endmodule

// File: rtl/tpc_bit_sel.sv
module tpc_bit_sel
   import tpc_pkg::*;
(
   input  tpc_mode_e mode,
   input  logic      use_pat,
   input  logic      pat_bit,
   input  logic      last_bit,
   output logic      nxt_bit
);

   always_comb begin
      if (use_pat) begin
         nxt_bit = pat_bit;
      end else begin
         unique case (mode)
            M_FLIP, M_ONCE_FLIP: nxt_bit = ~last_bit;
            M_ONES, M_ONCE_ONES: nxt_bit = 1'b1;
            default:             nxt_bit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/tpc_pattern_gen.sv
module tpc_pattern_gen
   import tpc_pkg::*;
#(
   parameter int   PAT_W    = 32,
   parameter logic INIT_BIT = 1'b0,
   localparam int  LEN_W    = $clog2(PAT_W + 1),
   localparam int  IDX_W    = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_i,
   input  logic             start_i,
   input  logic             slot_i,
   input  logic [PAT_W-1:0] pat_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             bit_o,
   output logic             done_o
);

   generate
      if (PAT_W < 1 || PAT_W > 1024) begin : g_bad_width
         $error("tpc_pattern_gen: PAT_W must lie in 1..1024");
      end
   endgenerate

   tpc_mode_e        mode;
   logic [IDX_W-1:0] last_idx, cur_idx;
   logic             use_pat, pat_bit, nxt_bit, bit_q;

   assign mode = tpc_mode_e'(mode_i);

   // length clamp: 0 -> 1 bit, above PAT_W -> PAT_W bits
   generate
      if (PAT_W == 1) begin : g_len_one
         assign last_idx = '0;
      end else begin : g_len_many
         logic [LEN_W-1:0] len_m1;
         always_comb begin
            if (len_i == '0)
               len_m1 = '0;
            else if (len_i > LEN_W'(PAT_W))
               len_m1 = LEN_W'(PAT_W - 1);
            else
               len_m1 = len_i - 1'b1;
         end
         assign last_idx = len_m1[IDX_W-1:0];
      end
   endgenerate

   assign pat_bit = pat_i[cur_idx];

   tpc_seq_ctrl #(
      .PAT_W (PAT_W),
      .IDX_W (IDX_W)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .start    (start_i),
      .slot     (slot_i),
      .last_idx (last_idx),
      .cur_idx  (cur_idx),
      .use_pat  (use_pat),
      .done     (done_o)
   );

   tpc_bit_sel i_sel (
      .mode     (mode),
      .use_pat  (use_pat),
      .pat_bit  (pat_bit),
      .last_bit (bit_q),
      .nxt_bit  (nxt_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bit_q <= INIT_BIT;
      else if (slot_i)
         bit_q <= nxt_bit;
   end

   assign bit_o = bit_q;

endmodule

// File: rtl/tpc_pattern_gen_chk.sv
module tpc_pattern_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_i,
   input logic       start_i,
   input logic       slot_i,
   input logic       bit_o,
   input logic       done_o
);

   // R2
   hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_i |=> $stable(bit_o));

   // R3
   flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && mode_i == 3'd0) |=> (bit_o != $past(bit_o)));

   // R4
   ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && mode_i == 3'd1) |=> bit_o);

   // R4
   zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && mode_i == 3'd2) |=> !bit_o);

   // R7
   loop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd6 && !start_i) |=> $stable(done_o));

   // R8
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !slot_i) |=> !done_o);

   // R8
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(slot_i));

endmodule

bind tpc_pattern_gen tpc_pattern_gen_chk i_tpc_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_i  (mode_i),
   .start_i (start_i),
   .slot_i  (slot_i),
   .bit_o   (bit_o),
   .done_o  (done_o)
);

// File: tb/test_tpc_pattern_gen.sv
module test_tpc_pattern_gen;

   localparam int PAT_W = 32;
   localparam int LEN_W = $clog2(PAT_W + 1);

   typedef struct {
      logic  b;
      logic  d;
      string tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       mode_i = 3'd0;
   logic             start_i = 1'b0;
   logic             slot_i = 1'b0;
   logic [PAT_W-1:0] pat_i = '0;
   logic [LEN_W-1:0] len_i = LEN_W'(1);
   logic             bit_o, done_o;

   int   total = 0;
   int   bad = 0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   tpc_pattern_gen #(.PAT_W(PAT_W)) i_tpc_pattern_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_i),
      .start_i (start_i),
      .slot_i  (slot_i),
      .pat_i   (pat_i),
      .len_i   (len_i),
      .bit_o   (bit_o),
      .done_o  (done_o)
   );

   task automatic check(input logic act_b, input logic exp_b,
                        input logic act_d, input logic exp_d, input string tag);
      total++;
      if (act_b !== exp_b || act_d !== exp_d) begin
         bad++;
         $display("FAIL %s: actual bit=%b done=%b expected bit=%b done=%b",
                  tag, act_b, act_d, exp_b, exp_d);
      end
   endtask

   // monitor: a strobe seen at the edge is checked just after the edge
   always @(posedge clk) begin
      if (rst_n && slot_i) begin
         #1;
         if (sb_q.size() == 0) begin
            check(bit_o, 1'bx, done_o, 1'bx, "R2 unexpected strobe");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(bit_o, e.b, done_o, e.d, e.tag);
         end
      end
   end

   task automatic slot(input logic b, input logic d, input string tag);
      @(negedge clk);
      slot_i = 1'b1;
      start_i = 1'b0;
      sb_q.push_back('{b: b, d: d, tag: tag});
      @(negedge clk);
      slot_i = 1'b0;
   endtask

   task automatic slot_with_start(input logic b, input logic d, input string tag);
      @(negedge clk);
      slot_i = 1'b1;
      start_i = 1'b1;
      sb_q.push_back('{b: b, d: d, tag: tag});
      @(negedge clk);
      slot_i = 1'b0;
      start_i = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      mode_i = m;
   endtask

   task automatic restart(input logic [2:0] m, input logic [PAT_W-1:0] p,
                          input logic [LEN_W-1:0] l);
      @(negedge clk);
      mode_i = m;
      pat_i = p;
      len_i = l;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      #800000;
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic held;
      repeat (3) @(negedge clk);
      // R1 reset values
      check(bit_o, 1'b0, done_o, 1'b0, "R1 reset state");
      rst_n = 1'b1;

      // R3 flip from reset value 0
      restart(3'd0, '0, LEN_W'(1));
      slot(1, 0, "R3 flip first");
      slot(0, 0, "R3 flip");
      slot(1, 0, "R3 flip");
      slot(0, 0, "R3 flip");

      // R4 constants and spare code
      set_mode(3'd1);
      for (int i = 0; i < 3; i++) slot(1, 0, "R4 ones");
      set_mode(3'd2);
      for (int i = 0; i < 2; i++) slot(0, 0, "R4 zeros");
      set_mode(3'd0);
      slot(1, 0, "R3 flip after zeros");
      slot(0, 0, "R3 flip");
      set_mode(3'd1);
      slot(1, 0, "R4 ones");
      set_mode(3'd0);
      slot(0, 0, "R3 flip after ones");
      slot(1, 0, "R3 flip");

      // R2 hold between strobes
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(bit_o, 1'b1, done_o, 1'b0, "R2 hold between strobes");
      end

      // R6 once then flip, pattern bits 1,0,1,1
      restart(3'd3, 32'b1101, LEN_W'(4));
      slot(1, 0, "R5 pattern bit0");
      slot(0, 0, "R5 pattern bit1");
      slot(1, 0, "R5 pattern bit2");
      slot(1, 1, "R8 done on last bit");
      slot(0, 1, "R6 flip tail complement");
      slot(1, 1, "R6 flip tail");
      slot(0, 1, "R8 done held");

      // R9 start alone keeps bit, R8 clears done
      restart(3'd3, 32'b1101, LEN_W'(4));
      @(negedge clk);
      check(bit_o, 1'b0, done_o, 1'b0, "R9 start keeps bit / R8 clear");

      // R6 once then ones, bits 0,1,0
      restart(3'd4, 32'b010, LEN_W'(3));
      slot(0, 0, "R5 pattern");
      slot(1, 0, "R5 pattern");
      slot(0, 1, "R8 done");
      slot(1, 1, "R6 ones tail");
      slot(1, 1, "R6 ones tail");

      // R6 once then zeros, bits 1,1
      restart(3'd5, 32'b11, LEN_W'(2));
      slot(1, 0, "R5 pattern");
      slot(1, 1, "R8 done");
      slot(0, 1, "R6 zeros tail");
      slot(0, 1, "R6 zeros tail");

      // R9 restart mid pattern, bits 0,1,1,0
      restart(3'd3, 32'b0110, LEN_W'(4));
      slot(0, 0, "R5 pattern");
      slot(1, 0, "R5 pattern");
      restart(3'd3, 32'b0110, LEN_W'(4));
      slot(0, 0, "R9 restart from bit0");
      slot(1, 0, "R9 restart");
      slot(1, 0, "R9 restart");
      slot(0, 1, "R8 done after restart");
      slot(1, 1, "R6 flip after pattern end");

      // R5 length 0 counts as 1
      restart(3'd3, 32'b0, LEN_W'(0));
      slot(0, 1, "R5 zero length one bit");
      slot(1, 1, "R6 flip tail");
      slot(0, 1, "R6 flip tail");

      // R7 loop, bits 1,1,0 repeating
      restart(3'd6, 32'b011, LEN_W'(3));
      for (int i = 0; i < 7; i++) slot((i % 3) != 2, 0, "R7 loop short");

      // R7 full-width loop with wrap
      restart(3'd6, 32'hA5F0_0F3C, LEN_W'(32));
      for (int i = 0; i < 40; i++) slot(pat_i[i % 32], 0, "R7 loop full");

      // R5 length above width clamps to width
      restart(3'd6, 32'h1357_9BDF, LEN_W'(40));
      for (int i = 0; i < 34; i++) slot(pat_i[i % 32], 0, "R5 length clamp");

      // R9 start together with strobe, bits 1,0
      @(negedge clk);
      mode_i = 3'd4;
      pat_i = 32'b01;
      len_i = LEN_W'(2);
      slot_with_start(1, 0, "R9 start with strobe");
      slot(0, 1, "R8 done");
      slot(1, 1, "R6 ones tail");

      // R4 spare code acts as zeros
      set_mode(3'd7);
      slot(0, 1, "R4 spare code zeros");
      held = bit_o;
      @(negedge clk);
      check(bit_o, held, done_o, 1'b1, "R2 hold after spare");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL R2 pending strobes: actual=%0d expected=0", sb_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule